// File: doc/BRIEF.md
# GPIO Controller with Level and Edge Interrupts

A register-mapped general-purpose I/O block for up to 32 pins. Software writes the output values and per-pin output enables, and reads back the pin levels after they pass through a two-flop synchroniser. Any pin can raise an interrupt on a level or on an edge, and the polarity of each is set per pin.

Level and edge interrupts take separate paths. A level source is evaluated live from the synchronised pin, its polarity bit and its mask bit. An edge source sets a sticky event bit. The event bit is recorded whether or not it is masked, and software clears it by writing a 1 to it. Every pending source is ORed into one summary status bit. A one-bit summary enable passes that bit to the interrupt output. Register reads are combinational from the presented address.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every register reads zero. `irq_o` is 0 and `pin_oe_o` is all zero, so every pin is an input.
- R2: Offset 0x44 holds the output values and offset 0x48 holds the output enables. Both read back as written. `pin_o` and `pin_oe_o` follow them from the cycle after the write, and they change on no other cycle.
- R3: Offset 0x40 returns `pin_i` two clock edges after it is applied, whatever the output enables hold. A write to 0x40 has no effect.
- R4: Offset 0x50 holds the level polarity (1 = active-low) and offset 0x54 holds the level mask. A pin's level source is pending when (level XOR polarity) AND mask is 1.
- R5: Offset 0x64 holds the edge polarity (0 = rising, 1 = falling). A detected edge sets the pin's bit in the event register at 0x58 one edge after the new level shows at 0x40. The bit is set even when the pin is masked. An event bit never sets without an edge.
- R6: Writing 1 to a bit of 0x58 clears that event bit. Writing 0 leaves it unchanged. An edge source is pending when its event bit AND its mask bit at 0x5C are both 1.
- R7: If a new edge and a clearing write hit the same event bit in the same cycle, the bit stays set.
- R8: Bit 0 of offset 0x00 is the OR of all pending level and edge sources. Writes to 0x00 are ignored. `irq_o` equals that bit ANDed with bit 0 of offset 0x04.
- R9: Any address outside the map reads zero and ignores writes. Bits at or above NUM_PINS read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register byte address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| pin_i | input | NUM_PINS | Raw pin levels |
| pin_o | output | NUM_PINS | Output values |
| pin_oe_o | output | NUM_PINS | Output enables |
| irq_o | output | 1 | Interrupt request |

## Verification
Edge capture and the write-1-to-clear on the event register can act on the same bit in the same clock. The bench raises a pin and then times a clearing write so that the write is sampled on the exact edge where the event would latch. The same write also clears a second bit that has no new edge. The bench expects the colliding bit to stay set and the other bit to clear. A cycle-accurate reference model checks every output on every clock and so judges the collision cycle as well.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned BUS_W  = 32;

  localparam logic [ADDR_W-1:0] ADR_STAT  = 8'h00;
  localparam logic [ADDR_W-1:0] ADR_SUMEN = 8'h04;
  localparam logic [ADDR_W-1:0] ADR_DIN   = 8'h40;
  localparam logic [ADDR_W-1:0] ADR_DOUT  = 8'h44;
  localparam logic [ADDR_W-1:0] ADR_OE    = 8'h48;
  localparam logic [ADDR_W-1:0] ADR_LPOL  = 8'h50;
  localparam logic [ADDR_W-1:0] ADR_LMASK = 8'h54;
  localparam logic [ADDR_W-1:0] ADR_EVENT = 8'h58;
  localparam logic [ADDR_W-1:0] ADR_EMASK = 8'h5C;
  localparam logic [ADDR_W-1:0] ADR_EPOL  = 8'h64;

  function automatic logic is_mapped(input logic [ADDR_W-1:0] a);
    return a inside {ADR_STAT, ADR_SUMEN, ADR_DIN, ADR_DOUT, ADR_OE,
                     ADR_LPOL, ADR_LMASK, ADR_EVENT, ADR_EMASK, ADR_EPOL};
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned NUM_PINS = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [NUM_PINS-1:0] epol_i,
  output logic [NUM_PINS-1:0] level_o,
  output logic [NUM_PINS-1:0] edge_o
);
  logic [NUM_PINS-1:0] s1_q, s2_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= pin_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign level_o = s2_q;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_edge
    // polarity 1 selects falling
    assign edge_o[g] = epol_i[g] ? (prev_q[g] & ~s2_q[g]) : (s2_q[g] & ~prev_q[g]);
  end
endmodule

// File: rtl/gpio_event_reg.sv
module gpio_event_reg #(
  parameter int unsigned NUM_PINS = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] edge_i,
  input  logic [NUM_PINS-1:0] clr_i,
  output logic [NUM_PINS-1:0] ev_o
);
  logic [NUM_PINS-1:0] ev_q;

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ev_q <= '0;
    else         ev_q <= (ev_q & ~clr_i) | edge_i;
  end

  assign ev_o = ev_q;
endmodule

// File: rtl/gpio_irq_sum.sv
module gpio_irq_sum #(
  parameter int unsigned NUM_PINS = 16
) (
  input  logic [NUM_PINS-1:0] level_i,
  input  logic [NUM_PINS-1:0] lpol_i,
  input  logic [NUM_PINS-1:0] lmask_i,
  input  logic [NUM_PINS-1:0] ev_i,
  input  logic [NUM_PINS-1:0] emask_i,
  input  logic                en_i,
  output logic                pend_o,
  output logic                irq_o
);
  logic [NUM_PINS-1:0] lvl_pend, edg_pend;

  assign lvl_pend = (level_i ^ lpol_i) & lmask_i;
  assign edg_pend = ev_i & emask_i;
  assign pend_o   = |(lvl_pend | edg_pend);
  assign irq_o    = pend_o & en_i;
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [7:0]          addr_i,
  input  logic                we_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic                irq_o
);
  localparam int unsigned N = NUM_PINS;

  logic [N-1:0] dout_q, oe_q, lpol_q, lmask_q, emask_q, epol_q;
  logic         sum_en_q;
  logic [N-1:0] level_w, edge_w, ev_q, clr_w, wpins;
  logic         pend_w;
  logic         unused_wdata;

  assign wpins        = wdata_i[N-1:0];
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q   <= '0;
      oe_q     <= '0;
      lpol_q   <= '0;
      lmask_q  <= '0;
      emask_q  <= '0;
      epol_q   <= '0;
      sum_en_q <= 1'b0;
    end else if (we_i) begin
      unique case (addr_i)
        ADR_DOUT:  dout_q   <= wpins;
        ADR_OE:    oe_q     <= wpins;
        ADR_LPOL:  lpol_q   <= wpins;
        ADR_LMASK: lmask_q  <= wpins;
        ADR_EMASK: emask_q  <= wpins;
        ADR_EPOL:  epol_q   <= wpins;
        ADR_SUMEN: sum_en_q <= wdata_i[0];
        default: ;
      endcase
    end
  end

  assign clr_w = (we_i && addr_i == ADR_EVENT) ? wpins : '0;

  gpio_in_sync #(.NUM_PINS(N)) i_sync (
    .clk_i, .rst_ni, .pin_i, .epol_i(epol_q), .level_o(level_w), .edge_o(edge_w)
  );

  gpio_event_reg #(.NUM_PINS(N)) i_event (
    .clk_i, .rst_ni, .edge_i(edge_w), .clr_i(clr_w), .ev_o(ev_q)
  );

  gpio_irq_sum #(.NUM_PINS(N)) i_sum (
    .level_i(level_w), .lpol_i(lpol_q), .lmask_i(lmask_q), .ev_i(ev_q),
    .emask_i(emask_q), .en_i(sum_en_q), .pend_o(pend_w), .irq_o
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADR_STAT:  rdata_o = 32'(pend_w);
      ADR_SUMEN: rdata_o = 32'(sum_en_q);
      ADR_DIN:   rdata_o = 32'(level_w);
      ADR_DOUT:  rdata_o = 32'(dout_q);
      ADR_OE:    rdata_o = 32'(oe_q);
      ADR_LPOL:  rdata_o = 32'(lpol_q);
      ADR_LMASK: rdata_o = 32'(lmask_q);
      ADR_EVENT: rdata_o = 32'(ev_q);
      ADR_EMASK: rdata_o = 32'(emask_q);
      ADR_EPOL:  rdata_o = 32'(epol_q);
      default:   rdata_o = '0;
    endcase
  end

  assign pin_o    = dout_q;
  assign pin_oe_o = oe_q;
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [7:0]          addr_i,
  input logic                we_i,
  input logic [31:0]         wdata_i,
  input logic [31:0]         rdata_o,
  input logic [NUM_PINS-1:0] pin_oe_o,
  input logic                irq_o,
  input logic [NUM_PINS-1:0] edge_i,
  input logic [NUM_PINS-1:0] ev_i,
  input logic                sum_en_i
);
  p_oe_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == ADR_OE) |=> $stable(pin_oe_o));

  p_ev_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((ev_i & ~$past(ev_i) & ~$past(edge_i)) == '0));

  p_w1c_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADR_EVENT) |=>
      ((ev_i & $past(wdata_i[NUM_PINS-1:0] & ~edge_i)) == '0));

  p_edge_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|edge_i) |=> ((ev_i & $past(edge_i)) == $past(edge_i)));

  p_irq_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> sum_en_i);

  p_unmapped_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_mapped(addr_i) |-> (rdata_o == '0));
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NUM_PINS(NUM_PINS)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .pin_oe_o(pin_oe_o), .irq_o(irq_o),
  .edge_i(edge_w), .ev_i(ev_q), .sum_en_i(sum_en_q)
);

// File: tb/test_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module test_gpio_irq_ctrl;
  localparam int N = 16;
  localparam logic [N-1:0] ALL = '1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   addr = 8'h00;
  logic         we = 1'b0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic [N-1:0] pins = '0;
  logic [N-1:0] pin_o, pin_oe;
  logic         irq;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  gpio_irq_ctrl #(.NUM_PINS(N)) i_gpio_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pin_i(pins), .pin_o(pin_o), .pin_oe_o(pin_oe), .irq_o(irq)
  );

  // reference model
  logic [N-1:0] m_s1, m_s2, m_prev, m_dout, m_oe, m_lpol, m_lmask, m_ev, m_emask, m_epol;
  logic         m_en;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_prev = '0; m_dout = '0; m_oe = '0;
      m_lpol = '0; m_lmask = '0; m_ev = '0; m_emask = '0; m_epol = '0; m_en = 0;
    end else begin
      logic [N-1:0] hit, clr;
      hit = '0;
      for (int i = 0; i < N; i++) begin
        if (m_epol[i] == 1'b0 && m_s2[i] && !m_prev[i]) hit[i] = 1'b1;
        if (m_epol[i] == 1'b1 && !m_s2[i] && m_prev[i]) hit[i] = 1'b1;
      end
      clr = (we && addr == 8'h58) ? wdata[N-1:0] : '0;
      if (we) begin
        if (addr == 8'h44) m_dout  = wdata[N-1:0];
        if (addr == 8'h48) m_oe    = wdata[N-1:0];
        if (addr == 8'h50) m_lpol  = wdata[N-1:0];
        if (addr == 8'h54) m_lmask = wdata[N-1:0];
        if (addr == 8'h5C) m_emask = wdata[N-1:0];
        if (addr == 8'h64) m_epol  = wdata[N-1:0];
        if (addr == 8'h04) m_en    = wdata[0];
      end
      m_ev   = (m_ev & ~clr) | hit;
      m_prev = m_s2;
      m_s2   = m_s1;
      m_s1   = pins;
    end
  end

  function automatic logic m_pend();
    return |(((m_s2 ^ m_lpol) & m_lmask) | (m_ev & m_emask));
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h00: return 32'(m_pend());
      8'h04: return 32'(m_en);
      8'h40: return 32'(m_s2);
      8'h44: return 32'(m_dout);
      8'h48: return 32'(m_oe);
      8'h50: return 32'(m_lpol);
      8'h54: return 32'(m_lmask);
      8'h58: return 32'(m_ev);
      8'h5C: return 32'(m_emask);
      8'h64: return 32'(m_epol);
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("[TB] FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      chk("R9 model rdata", rdata, m_read(addr));
      chk("R8 model irq", 32'(irq), 32'(m_pend() & m_en));
      chk("R2 model pin_o", 32'(pin_o), 32'(m_dout));
      chk("R2 model pin_oe", 32'(pin_oe), 32'(m_oe));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    addr = a; we = 1'b0;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("[TB] FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    foreach (m_read_addrs[i]) rd(m_read_addrs[i], 32'h0, "R1 reset value");
    chk("R1 irq after reset", 32'(irq), 32'h0);
    chk("R1 oe after reset", 32'(pin_oe), 32'h0);

    // R2 output data and enable
    wr(8'h44, 32'h0000A5A5);
    wr(8'h48, 32'h000000FF);
    rd(8'h44, 32'h0000A5A5, "R2 dout readback");
    rd(8'h48, 32'h000000FF, "R2 oe readback");
    chk("R2 pin_o", 32'(pin_o), 32'h0000A5A5);
    chk("R2 pin_oe", 32'(pin_oe), 32'h000000FF);

    // R3 input sampling, independent of oe; R5 rising events
    @(negedge clk); pins = 16'h1234;
    idle(4);
    rd(8'h40, 32'h00001234, "R3 data-in");
    wr(8'h40, 32'h0000FFFF);
    rd(8'h40, 32'h00001234, "R3 data-in write ignored");
    rd(8'h58, 32'h00001234, "R5 rising events latched unmasked");
    rd(8'h00, 32'h0, "R8 masked events not pending");

    // R6 write-1-to-clear
    wr(8'h58, 32'h00000204);
    rd(8'h58, 32'h00001030, "R6 w1c clears ones");
    wr(8'h58, 32'h0);
    rd(8'h58, 32'h00001030, "R6 zero write keeps");

    // R4 level path
    wr(8'h50, 32'h1);
    wr(8'h54, 32'h3);
    rd(8'h00, 32'h1, "R4 active-low level pending");
    chk("R8 irq gated off", 32'(irq), 32'h0);
    wr(8'h04, 32'h1);
    #1 chk("R8 irq enabled", 32'(irq), 32'h1);
    wr(8'h00, 32'h0);
    rd(8'h00, 32'h1, "R8 status write ignored");
    wr(8'h50, 32'h0);
    rd(8'h00, 32'h0, "R4 active-high low pin idle");
    chk("R8 irq drops", 32'(irq), 32'h0);

    // R5 falling edge with mask
    wr(8'h58, 32'h0000FFFF);
    wr(8'h64, 32'h00000010);
    wr(8'h5C, 32'h00000010);
    @(negedge clk); pins = 16'h1224;
    idle(4);
    rd(8'h58, 32'h00000010, "R5 falling event");
    rd(8'h00, 32'h1, "R6 masked event pending");
    chk("R8 irq from edge", 32'(irq), 32'h1);

    // R7 edge and clear in the same cycle
    @(negedge clk); pins = 16'h1324;
    @(negedge clk);
    wr(8'h58, 32'h00000110);
    rd(8'h58, 32'h00000100, "R7 edge beats clear");
    wr(8'h58, 32'h00000100);
    rd(8'h58, 32'h0, "R6 clear after collision");

    // R9 unmapped and high bits
    wr(8'h08, 32'hFFFFFFFF);
    rd(8'h08, 32'h0, "R9 unmapped read");
    rd(8'h4C, 32'h0, "R9 unmapped gap read");
    wr(8'h44, 32'hFFFFFFFF);
    rd(8'h44, 32'h0000FFFF, "R9 high bits zero");
    rd(8'h48, 32'h000000FF, "R9 unmapped write no effect");
    idle(3);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  logic [7:0] m_read_addrs [10] = '{8'h00, 8'h04, 8'h40, 8'h44, 8'h48,
                                    8'h50, 8'h54, 8'h58, 8'h5C, 8'h64};
endmodule